// File: doc/BRIEF.md
# Per-Core Local Interrupt Router

This block collects the interrupt lines of a four-core cluster and sends each one to the IRQ or FIQ input of a core. Each core has four timer lines and four mailbox lines of its own. Two more sources are shared by the whole cluster: a GPU controller, with one IRQ-class line and one FIQ-class line, and a performance-monitor line. Software programs the routing through a small register bus. The bus has an address, write data, a write strobe, a read strobe and registered read data.

For a timer or mailbox source, each core holds an 8-bit control word. The low nibble enables the four sources onto IRQ. The high nibble enables them onto FIQ, and a set FIQ bit takes the source away from IRQ. A routing word picks the single core that receives the GPU IRQ line, and another field in it picks the core for the GPU FIQ line. The performance-monitor enables are a per-core mask. Software changes that mask only through a write-one-to-set address and a write-one-to-clear address.

Each core has a read-only IRQ-pending word and a read-only FIQ-pending word. They show the live inputs after masking. The core's IRQ and FIQ outputs are the OR of those words, registered once.

Top module: `local_irq_router`

## Requirements
- R1: While reset is asserted, and right after it, every enable, the routing word and the mask are 0, and `core_irq` and `core_fiq` are low. Every mapped register reads 0 with all inputs idle.
- R2: Timer control word of core n: bits [3:0] are IRQ enables for timer lines 0..3. Timer line i of core n is `tmr_irq[4n+i]`. An enabled, active line with its FIQ enable clear sets IRQ-pending bit i: 0 secure physical, 1 non-secure physical, 2 hypervisor, 3 virtual.
- R3: Bits [7:4] of a control word are FIQ enables. When FIQ enable i is set, source i sets FIQ-pending bit i and never its IRQ-pending bit, whatever IRQ enable i holds.
- R4: Mailbox control word of core n uses the same layout as the timer word. Mailbox line i (`mbx_irq[4n+i]`) maps to pending bit 4+i in the IRQ or FIQ word.
- R5: Routing word bits [1:0] name the core whose IRQ-pending bit 8 follows `gpu_irq`. No other core's bit 8 is set by it. The word reads back as written in bits [3:0].
- R6: Routing word bits [3:2] name the core whose FIQ-pending bit 8 follows `gpu_fiq`.
- R7: Writing a mask to 0x010 sets those bits of the 4-bit performance-monitor enable. Writing to 0x014 clears them. Zero bits change nothing. Reading either address returns the mask in bits [3:0].
- R8: When `pmu_irq` is high, bit 9 of the IRQ-pending word is set in every core whose mask bit is set, and in no other core.
- R9: Offsets: routing 0x00C, timer control 0x040+4n, mailbox control 0x050+4n, IRQ-pending 0x060+4n, FIQ-pending 0x070+4n. A write to one core's word leaves the other cores unchanged.
- R10: A write to a pending address changes no state. The pending words still read as the masked inputs, and the outputs do not move.
- R11: A read of any unmapped or misaligned address returns 0.
- R12: `core_irq[n]` (`core_fiq[n]`) is the OR of core n's IRQ (FIQ) pending word as it was one clock edge earlier.
- R13: `bus_rdata` loads at a clock edge where `bus_rd` is high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid after the edge that samples `bus_rd` |
| tmr_irq | input | 16 | Timer lines, four per core |
| mbx_irq | input | 16 | Mailbox lines, four per core |
| gpu_irq | input | 1 | Shared GPU line for the IRQ class |
| gpu_fiq | input | 1 | Shared GPU line for the FIQ class |
| pmu_irq | input | 1 | Shared performance-monitor line |
| core_irq | output | 4 | IRQ per core |
| core_fiq | output | 4 | FIQ per core |

## Verification
A wrong control bit does not stay hidden. The pending word that reads it changes as soon as the matching line is driven, and the core output follows one edge later. A source with both enables set tells override from plain OR: if it shows in both pending words, or only in the IRQ word, the override logic is wrong. A bad routing field or a bad mask bit moves bit 8 or bit 9 to a different core's word, so each check reads the chosen core and one that was not chosen. A slip in decode or in the read register shows as a non-zero read of an unmapped address, a neighbour core's word that changed, or read data that moves while the read strobe is low.

// File: rtl/lirq_pkg.sv
`timescale 1ns/1ps
package lirq_pkg;

  localparam int SRC_GRP = 4;
  localparam int PEND_W  = 10;
  localparam int CIDX_W  = 2;
  localparam int MAP_AW  = 8;

  localparam logic [MAP_AW-1:0] OFF_GPU_RT   = 8'h0C;
  localparam logic [MAP_AW-1:0] OFF_PMU_SET  = 8'h10;
  localparam logic [MAP_AW-1:0] OFF_PMU_CLR  = 8'h14;
  localparam logic [MAP_AW-1:0] OFF_TMR_CTL  = 8'h40;
  localparam logic [MAP_AW-1:0] OFF_MBX_CTL  = 8'h50;
  localparam logic [MAP_AW-1:0] OFF_IRQ_PEND = 8'h60;
  localparam logic [MAP_AW-1:0] OFF_FIQ_PEND = 8'h70;

  localparam int BIT_TMR0 = 0;
  localparam int BIT_MBX0 = 4;
  localparam int BIT_GPU  = 8;
  localparam int BIT_PMU  = 9;

  typedef struct packed {
    logic [SRC_GRP-1:0] fiq_en;
    logic [SRC_GRP-1:0] irq_en;
  } grp_ctl_t;

  function automatic logic [SRC_GRP-1:0] grp_to_irq(
    input logic [SRC_GRP-1:0] lines, input grp_ctl_t ctl);
    return lines & ctl.irq_en & ~ctl.fiq_en;
  endfunction

  function automatic logic [SRC_GRP-1:0] grp_to_fiq(
    input logic [SRC_GRP-1:0] lines, input grp_ctl_t ctl);
    return lines & ctl.fiq_en;
  endfunction

  function automatic logic [MAP_AW-1:0] core_slot(
    input logic [MAP_AW-1:0] base, input int core);
    return base + MAP_AW'(4 * core);
  endfunction

  function automatic logic [SRC_GRP-1:0] mask_update(
    input logic [SRC_GRP-1:0] cur, input logic [SRC_GRP-1:0] bits,
    input logic do_set, input logic do_clr);
    logic [SRC_GRP-1:0] nxt;
    nxt = cur;
    if (do_set) nxt = nxt | bits;
    if (do_clr) nxt = nxt & ~bits;
    return nxt;
  endfunction

endpackage

// File: rtl/lirq_regs.sv
`timescale 1ns/1ps
module lirq_regs
  import lirq_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int DATA_W    = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_wr,
  input  logic [MAP_AW-1:0]           bus_addr,
  input  logic [DATA_W-1:0]           bus_wdata,
  output grp_ctl_t [NUM_CORES-1:0]    tmr_ctl,
  output grp_ctl_t [NUM_CORES-1:0]    mbx_ctl,
  output logic [CIDX_W-1:0]           gpu_irq_core,
  output logic [CIDX_W-1:0]           gpu_fiq_core,
  output logic [NUM_CORES-1:0]        pmu_en,
  output logic                        wr_pmu_set,
  output logic                        wr_pmu_clr
);

  localparam int CTL_W = $bits(grp_ctl_t);

  logic                 wr_gpu_rt;
  logic [SRC_GRP-1:0]   pmu_q;
  logic [SRC_GRP-1:0]   pmu_bits;

  assign wr_gpu_rt  = bus_wr && (bus_addr == OFF_GPU_RT);
  assign wr_pmu_set = bus_wr && (bus_addr == OFF_PMU_SET);
  assign wr_pmu_clr = bus_wr && (bus_addr == OFF_PMU_CLR);
  assign pmu_bits   = SRC_GRP'(bus_wdata[NUM_CORES-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gpu_irq_core <= '0;
      gpu_fiq_core <= '0;
    end else if (wr_gpu_rt) begin
      gpu_irq_core <= bus_wdata[CIDX_W-1:0];
      gpu_fiq_core <= bus_wdata[2*CIDX_W-1:CIDX_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pmu_q <= '0;
    else        pmu_q <= mask_update(pmu_q, pmu_bits, wr_pmu_set, wr_pmu_clr);
  end

  assign pmu_en = pmu_q[NUM_CORES-1:0];

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
    localparam logic [MAP_AW-1:0] TMR_A = core_slot(OFF_TMR_CTL, g);
    localparam logic [MAP_AW-1:0] MBX_A = core_slot(OFF_MBX_CTL, g);
    grp_ctl_t tmr_q;
    grp_ctl_t mbx_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            tmr_q <= '0;
      else if (bus_wr && bus_addr == TMR_A)  tmr_q <= bus_wdata[CTL_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            mbx_q <= '0;
      else if (bus_wr && bus_addr == MBX_A)  mbx_q <= bus_wdata[CTL_W-1:0];
    end

    assign tmr_ctl[g] = tmr_q;
    assign mbx_ctl[g] = mbx_q;
  end

endmodule

// File: rtl/lirq_core_steer.sv
`timescale 1ns/1ps
module lirq_core_steer
  import lirq_pkg::*;
#(
  parameter int CORE_ID = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SRC_GRP-1:0]  tmr_lines,
  input  logic [SRC_GRP-1:0]  mbx_lines,
  input  logic                gpu_irq,
  input  logic                gpu_fiq,
  input  logic                pmu_irq,
  input  grp_ctl_t            tmr_ctl,
  input  grp_ctl_t            mbx_ctl,
  input  logic [CIDX_W-1:0]   gpu_irq_core,
  input  logic [CIDX_W-1:0]   gpu_fiq_core,
  input  logic                pmu_en,
  output logic [PEND_W-1:0]   irq_pend,
  output logic [PEND_W-1:0]   fiq_pend,
  output logic                irq_o,
  output logic                fiq_o
);

  localparam logic [CIDX_W-1:0] MY_ID = CIDX_W'(CORE_ID);

  logic gpu_irq_here;
  logic gpu_fiq_here;

  assign gpu_irq_here = gpu_irq && (gpu_irq_core == MY_ID);
  assign gpu_fiq_here = gpu_fiq && (gpu_fiq_core == MY_ID);

  always_comb begin
    irq_pend = '0;
    fiq_pend = '0;
    irq_pend[BIT_TMR0 +: SRC_GRP] = grp_to_irq(tmr_lines, tmr_ctl);
    fiq_pend[BIT_TMR0 +: SRC_GRP] = grp_to_fiq(tmr_lines, tmr_ctl);
    irq_pend[BIT_MBX0 +: SRC_GRP] = grp_to_irq(mbx_lines, mbx_ctl);
    fiq_pend[BIT_MBX0 +: SRC_GRP] = grp_to_fiq(mbx_lines, mbx_ctl);
    irq_pend[BIT_GPU]             = gpu_irq_here;
    fiq_pend[BIT_GPU]             = gpu_fiq_here;
    irq_pend[BIT_PMU]             = pmu_irq && pmu_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o <= 1'b0;
      fiq_o <= 1'b0;
    end else begin
      irq_o <= |irq_pend;
      fiq_o <= |fiq_pend;
    end
  end

endmodule

// File: rtl/lirq_rd_mux.sv
`timescale 1ns/1ps
module lirq_rd_mux
  import lirq_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int DATA_W    = 32
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 bus_rd,
  input  logic [MAP_AW-1:0]                    bus_addr,
  input  grp_ctl_t [NUM_CORES-1:0]             tmr_ctl,
  input  grp_ctl_t [NUM_CORES-1:0]             mbx_ctl,
  input  logic [CIDX_W-1:0]                    gpu_irq_core,
  input  logic [CIDX_W-1:0]                    gpu_fiq_core,
  input  logic [NUM_CORES-1:0]                 pmu_en,
  input  logic [NUM_CORES-1:0][PEND_W-1:0]     irq_pend_all,
  input  logic [NUM_CORES-1:0][PEND_W-1:0]     fiq_pend_all,
  output logic [DATA_W-1:0]                    bus_rdata
);

  localparam int CTL_W = $bits(grp_ctl_t);

  logic [DATA_W-1:0] rd_val;

  always_comb begin
    rd_val = '0;
    if (bus_addr == OFF_GPU_RT)
      rd_val[2*CIDX_W-1:0] = {gpu_fiq_core, gpu_irq_core};
    if (bus_addr == OFF_PMU_SET || bus_addr == OFF_PMU_CLR)
      rd_val[NUM_CORES-1:0] = pmu_en;
    for (int c = 0; c < NUM_CORES; c++) begin
      if (bus_addr == core_slot(OFF_TMR_CTL, c))  rd_val[CTL_W-1:0]  = tmr_ctl[c];
      if (bus_addr == core_slot(OFF_MBX_CTL, c))  rd_val[CTL_W-1:0]  = mbx_ctl[c];
      if (bus_addr == core_slot(OFF_IRQ_PEND, c)) rd_val[PEND_W-1:0] = irq_pend_all[c];
      if (bus_addr == core_slot(OFF_FIQ_PEND, c)) rd_val[PEND_W-1:0] = fiq_pend_all[c];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
  end

endmodule

// File: rtl/local_irq_router.sv
`timescale 1ns/1ps
module local_irq_router
  import lirq_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int DATA_W    = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [MAP_AW-1:0]             bus_addr,
  input  logic [DATA_W-1:0]             bus_wdata,
  input  logic                          bus_wr,
  input  logic                          bus_rd,
  output logic [DATA_W-1:0]             bus_rdata,
  input  logic [NUM_CORES*SRC_GRP-1:0]  tmr_irq,
  input  logic [NUM_CORES*SRC_GRP-1:0]  mbx_irq,
  input  logic                          gpu_irq,
  input  logic                          gpu_fiq,
  input  logic                          pmu_irq,
  output logic [NUM_CORES-1:0]          core_irq,
  output logic [NUM_CORES-1:0]          core_fiq
);

  grp_ctl_t [NUM_CORES-1:0]          tmr_ctl;
  grp_ctl_t [NUM_CORES-1:0]          mbx_ctl;
  logic [CIDX_W-1:0]                 gpu_irq_core;
  logic [CIDX_W-1:0]                 gpu_fiq_core;
  logic [NUM_CORES-1:0]              pmu_en;
  logic                              wr_pmu_set;
  logic                              wr_pmu_clr;
  logic [NUM_CORES-1:0][PEND_W-1:0]  irq_pend_all;
  logic [NUM_CORES-1:0][PEND_W-1:0]  fiq_pend_all;

  lirq_regs #(.NUM_CORES(NUM_CORES), .DATA_W(DATA_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .tmr_ctl      (tmr_ctl),
    .mbx_ctl      (mbx_ctl),
    .gpu_irq_core (gpu_irq_core),
    .gpu_fiq_core (gpu_fiq_core),
    .pmu_en       (pmu_en),
    .wr_pmu_set   (wr_pmu_set),
    .wr_pmu_clr   (wr_pmu_clr)
  );

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_steer
    lirq_core_steer #(.CORE_ID(g)) u_steer (
      .clk          (clk),
      .rst_n        (rst_n),
      .tmr_lines    (tmr_irq[g*SRC_GRP +: SRC_GRP]),
      .mbx_lines    (mbx_irq[g*SRC_GRP +: SRC_GRP]),
      .gpu_irq      (gpu_irq),
      .gpu_fiq      (gpu_fiq),
      .pmu_irq      (pmu_irq),
      .tmr_ctl      (tmr_ctl[g]),
      .mbx_ctl      (mbx_ctl[g]),
      .gpu_irq_core (gpu_irq_core),
      .gpu_fiq_core (gpu_fiq_core),
      .pmu_en       (pmu_en[g]),
      .irq_pend     (irq_pend_all[g]),
      .fiq_pend     (fiq_pend_all[g]),
      .irq_o        (core_irq[g]),
      .fiq_o        (core_fiq[g])
    );
  end

  lirq_rd_mux #(.NUM_CORES(NUM_CORES), .DATA_W(DATA_W)) u_rd (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_rd       (bus_rd),
    .bus_addr     (bus_addr),
    .tmr_ctl      (tmr_ctl),
    .mbx_ctl      (mbx_ctl),
    .gpu_irq_core (gpu_irq_core),
    .gpu_fiq_core (gpu_fiq_core),
    .pmu_en       (pmu_en),
    .irq_pend_all (irq_pend_all),
    .fiq_pend_all (fiq_pend_all),
    .bus_rdata    (bus_rdata)
  );

endmodule

// File: rtl/lirq_router_chk.sv
`timescale 1ns/1ps
module lirq_router_chk
  import lirq_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int DATA_W    = 32
) (
  input logic                               clk,
  input logic                               rst_n,
  input logic [MAP_AW-1:0]                  bus_addr,
  input logic [DATA_W-1:0]                  bus_wdata,
  input logic                               bus_wr,
  input logic                               bus_rd,
  input logic [DATA_W-1:0]                  bus_rdata,
  input logic [NUM_CORES-1:0]               core_irq,
  input logic [NUM_CORES-1:0]               core_fiq,
  input logic [NUM_CORES-1:0]               pmu_en,
  input logic                               wr_pmu_set,
  input logic                               wr_pmu_clr,
  input logic [NUM_CORES-1:0][PEND_W-1:0]   irq_pend_all,
  input logic [NUM_CORES-1:0][PEND_W-1:0]   fiq_pend_all
);

  logic [NUM_CORES-1:0] gpu_irq_bits;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core_chk
    assign gpu_irq_bits[c] = irq_pend_all[c][BIT_GPU];

    p_irq_latency_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> core_irq[c] == $past(|irq_pend_all[c]));

    p_fiq_latency_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> core_fiq[c] == $past(|fiq_pend_all[c]));

    p_fiq_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_pend_all[c][BIT_MBX0+SRC_GRP-1:0] & fiq_pend_all[c][BIT_MBX0+SRC_GRP-1:0]) == '0);
  end

  p_gpu_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gpu_irq_bits));

  p_pmu_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pmu_set && !wr_pmu_clr) |=>
      ((pmu_en & $past(bus_wdata[NUM_CORES-1:0])) == $past(bus_wdata[NUM_CORES-1:0])));

  p_pmu_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pmu_clr |=> ((pmu_en & $past(bus_wdata[NUM_CORES-1:0])) == '0));

  p_pmu_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_pmu_set || wr_pmu_clr) |=> $stable(pmu_en));

  p_rdata_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

  p_quiet_in_reset_r1: assert property (@(posedge clk)
    !rst_n |-> (core_irq == '0 && core_fiq == '0 && pmu_en == '0));

endmodule

bind local_irq_router lirq_router_chk #(.NUM_CORES(NUM_CORES), .DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .bus_wr       (bus_wr),
  .bus_rd       (bus_rd),
  .bus_rdata    (bus_rdata),
  .core_irq     (core_irq),
  .core_fiq     (core_fiq),
  .pmu_en       (pmu_en),
  .wr_pmu_set   (wr_pmu_set),
  .wr_pmu_clr   (wr_pmu_clr),
  .irq_pend_all (irq_pend_all),
  .fiq_pend_all (fiq_pend_all)
);

// File: tb/local_irq_router_bench.sv
`timescale 1ns/1ps
module local_irq_router_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [15:0] tmr_irq = '0;
  logic [15:0] mbx_irq = '0;
  logic        gpu_irq = 1'b0;
  logic        gpu_fiq = 1'b0;
  logic        pmu_irq = 1'b0;
  logic [3:0]  core_irq;
  logic [3:0]  core_fiq;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  local_irq_router u_local_irq_router (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .tmr_irq(tmr_irq), .mbx_irq(mbx_irq), .gpu_irq(gpu_irq), .gpu_fiq(gpu_fiq),
    .pmu_irq(pmu_irq), .core_irq(core_irq), .core_fiq(core_fiq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); #1;
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic settle;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 core_irq", {28'd0, core_irq}, 32'd0);
    check("R1 core_fiq", {28'd0, core_fiq}, 32'd0);
    rd_chk("R1 gpu route", 8'h0C, 0);
    rd_chk("R1 pmu mask", 8'h10, 0);
    for (int c = 0; c < 4; c++) begin
      rd_chk("R1 timer ctl", 8'h40 + 8'(4*c), 0);
      rd_chk("R1 mailbox ctl", 8'h50 + 8'(4*c), 0);
      rd_chk("R1 irq pend", 8'h60 + 8'(4*c), 0);
    end
  endtask

  task automatic t_timer;
    wr(8'h48, 32'h05);
    rd_chk("R9 core2 timer ctl", 8'h48, 32'h05);
    rd_chk("R9 core0 timer untouched", 8'h40, 0);
    @(negedge clk); tmr_irq[11:8] = 4'hF;
    settle();
    rd_chk("R2 core2 irq pend", 8'h68, 32'h005);
    rd_chk("R2 core2 fiq pend", 8'h78, 0);
    rd_chk("R9 core1 irq pend", 8'h64, 0);
    check("R2 core_irq", {28'd0, core_irq}, 32'h4);
    wr(8'h48, 32'h45);
    settle();
    rd_chk("R3 core2 irq pend", 8'h68, 32'h001);
    rd_chk("R3 core2 fiq pend", 8'h78, 32'h004);
    check("R3 core_fiq", {28'd0, core_fiq}, 32'h4);
    @(negedge clk); tmr_irq = '0;
    wr(8'h48, 0);
  endtask

  task automatic t_mailbox;
    wr(8'h54, 32'h93);
    @(negedge clk); mbx_irq[7:4] = 4'hF;
    settle();
    rd_chk("R4 core1 irq pend", 8'h64, 32'h020);
    rd_chk("R4 core1 fiq pend", 8'h74, 32'h090);
    check("R4 outputs", {24'd0, core_fiq, core_irq}, 32'h22);
    @(negedge clk); mbx_irq = '0;
    wr(8'h54, 0);
  endtask

  task automatic t_gpu;
    wr(8'h0C, 32'hFFFF_FF0B);
    rd_chk("R5 route readback", 8'h0C, 32'h0B);
    @(negedge clk); gpu_irq = 1'b1;
    settle();
    rd_chk("R5 core3 irq pend", 8'h6C, 32'h100);
    rd_chk("R5 core0 irq pend", 8'h60, 0);
    check("R5 core_irq", {28'd0, core_irq}, 32'h8);
    @(negedge clk); gpu_irq = 1'b0; gpu_fiq = 1'b1;
    settle();
    rd_chk("R6 core2 fiq pend", 8'h78, 32'h100);
    rd_chk("R6 core3 fiq pend", 8'h7C, 0);
    check("R6 core_fiq", {28'd0, core_fiq}, 32'h4);
    @(negedge clk); gpu_fiq = 1'b0;
    wr(8'h0C, 0);
  endtask

  task automatic t_pmu;
    wr(8'h10, 32'h5);
    rd_chk("R7 set", 8'h10, 32'h5);
    wr(8'h10, 32'h2);
    rd_chk("R7 set keeps others", 8'h10, 32'h7);
    wr(8'h14, 32'h4);
    rd_chk("R7 clear via clr addr", 8'h14, 32'h3);
    wr(8'h14, 32'h0);
    rd_chk("R7 zero clear no change", 8'h10, 32'h3);
    @(negedge clk); pmu_irq = 1'b1;
    settle();
    rd_chk("R8 core0 irq pend", 8'h60, 32'h200);
    rd_chk("R8 core2 irq pend", 8'h68, 0);
    check("R8 core_irq", {28'd0, core_irq}, 32'h3);
    @(negedge clk); pmu_irq = 1'b0;
    wr(8'h14, 32'hF);
    rd_chk("R7 all cleared", 8'h10, 0);
  endtask

  task automatic t_readonly;
    wr(8'h40, 32'h01);
    @(negedge clk); tmr_irq[0] = 1'b1;
    settle();
    wr(8'h60, 32'hFFFF_FFFF);
    wr(8'h70, 32'hFFFF_FFFF);
    wr(8'h64, 32'hFFFF_FFFF);
    rd_chk("R10 irq pend kept", 8'h60, 32'h001);
    rd_chk("R10 fiq pend kept", 8'h70, 0);
    rd_chk("R10 ctl kept", 8'h40, 32'h01);
    rd_chk("R10 core1 pend kept", 8'h64, 0);
    check("R10 outputs", {24'd0, core_fiq, core_irq}, 32'h01);
    @(negedge clk); tmr_irq = '0;
    wr(8'h40, 0);
  endtask

  task automatic t_unmapped;
    wr(8'h04, 32'hFFFF_FFFF);
    rd_chk("R11 addr 04", 8'h04, 0);
    rd_chk("R11 addr 20", 8'h20, 0);
    rd_chk("R11 misaligned 41", 8'h41, 0);
    rd_chk("R11 addr 80", 8'h80, 0);
    rd_chk("R11 addr FC", 8'hFC, 0);
  endtask

  task automatic t_latency;
    wr(8'h40, 32'h08);
    @(negedge clk); tmr_irq[3] = 1'b1;
    #1;
    check("R12 before edge", {31'd0, core_irq[0]}, 0);
    @(posedge clk); #1;
    check("R12 after one edge", {31'd0, core_irq[0]}, 1);
    @(negedge clk); tmr_irq[3] = 1'b0;
    #1;
    check("R12 hold before edge", {31'd0, core_irq[0]}, 1);
    @(posedge clk); #1;
    check("R12 drop after edge", {31'd0, core_irq[0]}, 0);
  endtask

  task automatic t_rd_hold;
    rd_chk("R13 read", 8'h40, 32'h08);
    wr(8'h40, 32'h00);
    @(negedge clk); bus_addr = 8'h0C;
    settle();
    check("R13 rdata held", bus_rdata, 32'h08);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_timer();
    t_mailbox();
    t_gpu();
    t_pmu();
    t_readonly();
    t_unmapped();
    t_latency();
    t_rd_hold();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule